// File: doc/BRIEF.md
# Vector Sequencer with Break Detect

This block steps a vector address counter through an instruction memory. It fetches one instruction word per clock and presents that word downstream as the current vector. A word whose break bit is clear is treated as a no-operation, and the counter simply advances. When the counter passes the top of memory it wraps to zero and keeps going. A word with the break bit set halts the sequencer on that address.

A host loads the instruction memory through a write port. It launches a run with a one-cycle start pulse and can end a run with a one-cycle stop pulse. It then polls a status word. The status word shows whether the engine is running, whether the last halt came from a break, and the address at which it halted. The host can use this to self-test the break path. It first fills memory with no-operations and confirms the engine is still running. It then places a break on the next-to-last vector and confirms the engine stopped there without wrapping.

Top module: `vecseq_brk`

## Requirements
- R1: After reset, `status` and `vec_addr` are all zeros and the sequencer is idle.
- R2: The status word layout is: bit ADDR_W+1 = running, bit ADDR_W = halted-by-break flag, bits ADDR_W-1..0 = halt address. One clock after a `start_cmd` pulse, running is 1, `vec_addr` is 0, and the flag and halt address are 0.
- R3: While running, a fetched word with bit BRK_BIT clear advances `vec_addr` by one on the next clock.
- R4: With every memory word zero, the sequencer still reports running at any later poll after a start.
- R5: While running, a fetched word with bit BRK_BIT set produces the following state on the next clock: running is 0, the flag is 1, the halt address equals that word's address, and `vec_addr` holds.
- R6: Stepping from address 2^ADDR_W-1 wraps `vec_addr` to 0 and running stays 1.
- R7: A `stop_cmd` while running produces the following state on the next clock: running is 0, the flag is 0, the halt address equals the address held at the stop, and `vec_addr` holds.
- R8: When `start_cmd` and `stop_cmd` arrive in the same cycle, start wins.
- R9: Every instruction bit other than BRK_BIT has no effect on sequencing. The fetched word appears unchanged on `vec_word`.
- R10: While idle, `stop_cmd` has no effect and `vec_addr` does not move.
- R11: A word written through the write port is the one fetched at that address on any later cycle, including while running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Instruction memory write strobe |
| wr_addr | input | ADDR_W | Instruction memory write address |
| wr_data | input | INSTR_W | Instruction word to write |
| start_cmd | input | 1 | One-cycle pulse: restart at address 0 and run |
| stop_cmd | input | 1 | One-cycle pulse: halt a running sequence |
| status | output | ADDR_W+2 | {running, break flag, halt address} |
| vec_addr | output | ADDR_W | Current vector address |
| vec_word | output | INSTR_W | Instruction word fetched at `vec_addr` |

## Verification
The bench builds the block with ADDR_W=5, INSTR_W=12 and BRK_BIT=11. The 32-entry memory lets a run cross the wrap from 31 to 0 several times within a few dozen cycles. It also puts the next-to-last vector (30) one step from that wrap. A word with every non-break bit set sits on the path, to show those bits are ignored. A break is also placed at address 0, so that the halt lands on the very first fetch after a start.

// File: rtl/vecseq_pkg.sv
package vecseq_pkg;
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_START = 3'd1,
    OP_STOP  = 3'd2,
    OP_BREAK = 3'd3,
    OP_STEP  = 3'd4
  } seq_op_e;
endpackage

// File: rtl/vecseq_rst_sync.sv
module vecseq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/vecseq_iram.sv
module vecseq_iram #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/vecseq_ctrl.sv
module vecseq_ctrl
  import vecseq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_cmd,
  input  logic              stop_cmd,
  input  logic              fetch_brk,
  output logic [ADDR_W-1:0] addr,
  output logic              running,
  output logic              brk_flag,
  output logic [ADDR_W-1:0] halt_addr
);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              run_q, run_d;
  logic              brk_q, brk_d;
  logic [ADDR_W-1:0] halt_q, halt_d;
  seq_op_e           op;
  logic              upd_en;

  always_comb begin
    if (start_cmd)                op = OP_START;
    else if (run_q && stop_cmd)   op = OP_STOP;
    else if (run_q && fetch_brk)  op = OP_BREAK;
    else if (run_q)               op = OP_STEP;
    else                          op = OP_HOLD;
  end

  always_comb begin
    addr_d = addr_q;
    run_d  = run_q;
    brk_d  = brk_q;
    halt_d = halt_q;
    case (op)
      OP_START: begin
        addr_d = '0;
        run_d  = 1'b1;
        brk_d  = 1'b0;
        halt_d = '0;
      end
      OP_STOP: begin
        run_d  = 1'b0;
        brk_d  = 1'b0;
        halt_d = addr_q;
      end
      OP_BREAK: begin
        run_d  = 1'b0;
        brk_d  = 1'b1;
        halt_d = addr_q;
      end
      OP_STEP: begin
        addr_d = addr_q + ADDR_ONE;
      end
      default: ;
    endcase
  end

  assign upd_en = (op != OP_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      run_q  <= 1'b0;
      brk_q  <= 1'b0;
      halt_q <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      run_q  <= run_d;
      brk_q  <= brk_d;
      halt_q <= halt_d;
    end
  end

  assign addr      = addr_q;
  assign running   = run_q;
  assign brk_flag  = brk_q;
  assign halt_addr = halt_q;
endmodule

// File: rtl/vecseq_brk.sv
module vecseq_brk #(
  parameter int ADDR_W      = 8,
  parameter int INSTR_W     = 16,
  parameter int BRK_BIT     = 15,
  parameter int SYNC_STAGES = 2,
  localparam int STAT_W     = ADDR_W + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [INSTR_W-1:0] wr_data,
  input  logic               start_cmd,
  input  logic               stop_cmd,
  output logic [STAT_W-1:0]  status,
  output logic [ADDR_W-1:0]  vec_addr,
  output logic [INSTR_W-1:0] vec_word
);
  logic               rst_q_n;
  logic [ADDR_W-1:0]  cur_addr;
  logic [INSTR_W-1:0] fetch_word;
  logic               fetch_brk;
  logic               running;
  logic               brk_flag;
  logic [ADDR_W-1:0]  halt_addr;

  vecseq_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_q_n)
  );

  vecseq_iram #(.ADDR_W(ADDR_W), .DATA_W(INSTR_W)) u_iram (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (wr_data),
    .raddr (cur_addr),
    .rdata (fetch_word)
  );

  assign fetch_brk = fetch_word[BRK_BIT];

  vecseq_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .start_cmd (start_cmd),
    .stop_cmd  (stop_cmd),
    .fetch_brk (fetch_brk),
    .addr      (cur_addr),
    .running   (running),
    .brk_flag  (brk_flag),
    .halt_addr (halt_addr)
  );

  assign status   = {running, brk_flag, halt_addr};
  assign vec_addr = cur_addr;
  assign vec_word = fetch_word;
endmodule

// File: rtl/vecseq_brk_chk.sv
module vecseq_brk_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              start_cmd,
  input logic              stop_cmd,
  input logic              fetch_brk,
  input logic [ADDR_W+1:0] status,
  input logic [ADDR_W-1:0] vec_addr
);
  localparam int RUN_B = ADDR_W + 1;
  localparam int BRK_B = ADDR_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  // R2
  start_runs_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    start_cmd |=> status[RUN_B] && !status[BRK_B] && vec_addr == '0);

  // R3
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (status[RUN_B] && !start_cmd && !stop_cmd && !fetch_brk)
      |=> status[RUN_B] && vec_addr == $past(vec_addr) + ONE);

  // R5
  break_halt_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (status[RUN_B] && !start_cmd && !stop_cmd && fetch_brk)
      |=> !status[RUN_B] && status[BRK_B]
          && status[ADDR_W-1:0] == $past(vec_addr) && $stable(vec_addr));

  // R7
  stop_halt_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (status[RUN_B] && !start_cmd && stop_cmd)
      |=> !status[RUN_B] && !status[BRK_B]
          && status[ADDR_W-1:0] == $past(vec_addr) && $stable(vec_addr));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!status[RUN_B] && !start_cmd) |=> !status[RUN_B] && $stable(status) && $stable(vec_addr));
endmodule

bind vecseq_brk vecseq_brk_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .start_cmd (start_cmd),
  .stop_cmd  (stop_cmd),
  .fetch_brk (fetch_brk),
  .status    (status),
  .vec_addr  (vec_addr)
);

// File: tb/tb_vecseq_brk.sv
module tb_vecseq_brk;
  localparam int AW    = 5;
  localparam int IW    = 12;
  localparam int BB    = 11;
  localparam int DEPTH = 1 << AW;

  logic          clk;
  logic          rst_n;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [IW-1:0] wr_data;
  logic          start_cmd;
  logic          stop_cmd;
  logic [AW+1:0] status;
  logic [AW-1:0] vec_addr;
  logic [IW-1:0] vec_word;

  int total = 0;
  int bad   = 0;

  // behavioural reference state
  int m_mem [DEPTH];
  int m_addr, m_halt;
  bit m_run, m_brk;

  vecseq_brk #(.ADDR_W(AW), .INSTR_W(IW), .BRK_BIT(BB)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .start_cmd(start_cmd), .stop_cmd(stop_cmd),
    .status(status), .vec_addr(vec_addr), .vec_word(vec_word)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_run = 0; m_brk = 0; m_addr = 0; m_halt = 0;
    end else begin
      int word;
      word = m_mem[m_addr];
      if (start_cmd) begin
        m_run = 1; m_brk = 0; m_addr = 0; m_halt = 0;
      end else if (m_run && stop_cmd) begin
        m_run = 0; m_brk = 0; m_halt = m_addr;
      end else if (m_run && ((word >> BB) & 1) == 1) begin
        m_run = 0; m_brk = 1; m_halt = m_addr;
      end else if (m_run) begin
        m_addr = (m_addr + 1) % DEPTH;
      end
    end
    if (wr_en) m_mem[wr_addr] = int'(wr_data);
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int m_status();
    return (int'(m_run) << (AW + 1)) | (int'(m_brk) << AW) | m_halt;
  endfunction

  // per-cycle comparison against the reference, away from the active edge
  bit cmp_on = 0;
  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R3 R5 R7 model status", int'(status), m_status());
      chk("R3 R6 model addr", int'(vec_addr), m_addr);
      chk("R9 R11 model word", int'(vec_word), m_mem[m_addr]);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    wr_en = 1; wr_addr = AW'(a); wr_data = IW'(d);
    cyc(1);
    wr_en = 0;
  endtask

  task automatic pulse(input bit s, input bit p);
    start_cmd = s; stop_cmd = p;
    cyc(1);
    start_cmd = 0; stop_cmd = 0;
  endtask

  localparam int RUNB = 1 << (AW + 1);
  localparam int BRKB = 1 << AW;

  initial begin
    for (int i = 0; i < DEPTH; i++) m_mem[i] = 0;
    rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0; start_cmd = 0; stop_cmd = 0;
    cyc(4);
    rst_n = 1;
    cyc(4);
    // R1
    chk("R1 reset status", int'(status), 0);
    chk("R1 reset addr", int'(vec_addr), 0);

    // R11: fill memory with NOPs
    for (int i = 0; i < DEPTH; i++) wr(i, 0);
    cmp_on = 1;

    // R10: stop while idle does nothing
    pulse(0, 1);
    chk("R10 idle stop status", int'(status), 0);
    cyc(3);
    chk("R10 idle addr", int'(vec_addr), 0);

    // R2
    pulse(1, 0);
    chk("R2 start status", int'(status), RUNB);
    chk("R2 start addr", int'(vec_addr), 0);
    cyc(5);
    chk("R3 step addr", int'(vec_addr), 5);
    cyc(27);
    chk("R6 wrap addr", int'(vec_addr), 0);
    chk("R6 run after wrap", int'(status[AW+1]), 1);
    cyc(40);
    chk("R4 NOP still running", int'(status[AW+1]), 1);

    // R7: addr now (32+40) mod 32 = 8
    pulse(0, 1);
    chk("R7 stop status", int'(status), 8);
    cyc(2);
    chk("R7 addr holds", int'(vec_addr), 8);

    // R9 and R5: non-break bits set at 5, break at next-to-last vector
    wr(5, (1 << BB) - 1);
    wr(DEPTH - 2, (1 << BB) | 'h0A5);
    pulse(1, 0);
    cyc(5);
    chk("R9 word passes", int'(vec_word), (1 << BB) - 1);
    chk("R9 ignored bits", int'(status), RUNB);
    cyc(40);
    chk("R5 break status", int'(status), BRKB | (DEPTH - 2));
    chk("R5 no wrap addr", int'(vec_addr), DEPTH - 2);

    // R8: simultaneous start and stop
    pulse(1, 1);
    chk("R8 start wins", int'(status), RUNB);
    chk("R8 addr zero", int'(vec_addr), 0);
    cyc(3);

    // R11: write a break ahead of the running counter (addr now 3)
    wr(10, 1 << BB);
    cyc(12);
    chk("R11 live write break", int'(status), BRKB | 10);

    // R5 corner: break at address 0 halts on the first fetch
    wr(0, 1 << BB);
    pulse(1, 0);
    chk("R5 first fetch run", int'(status), RUNB);
    cyc(1);
    chk("R5 break at zero", int'(status), BRKB);
    cyc(2);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule